// File: doc/BRIEF.md
# Stack Operation Bus Sequencer

This block generates the bus cycles of the stack-related instructions of an 8-bit processor with a 16-bit address bus: push, pull, subroutine call, subroutine return, interrupt return and software break. A start pulse, an operation code, the program counter, the stack pointer and a byte to store are sampled together. From the next cycle on, the block drives one bus action per clock, either a read or a write, on a fully defined address. Dummy reads also carry a defined address.

The attached memory is combinational and answers every read in the same cycle. The bus therefore has no back-pressure: `bus_valid` marks a live action and there is no ready signal. A sequence can be neither paused nor stretched. `done` rises together with the final action. At the clock edge that ends that action, the block loads the new stack pointer and the fetched 16-bit value into `sp_out` and `target`. Both hold until the next operation completes. Stack addresses are formed from page 0x01 and an 8-bit offset that wraps inside that page.

Top module: `stk_bus_seq`

## Requirements
- R1: Push (op 0) runs for 3 cycles: read at PC, read at PC+1, then a write of `wr_byte` at stack offset SP. Afterwards `sp_out` = SP-1 and `target` = 0x0000.
- R2: Pull (op 1) runs for 4 cycles: reads at PC, PC+1, stack SP, then stack SP+1. Afterwards `sp_out` = SP+1 and `target` = {0x00, the byte read at SP+1}.
- R3: Every stack access has address bits 15..8 equal to 0x01. Bits 7..0 are the stack offset computed modulo 256, so SP+1 from 0xFF gives 0x0100 and SP-1 from 0x00 gives 0x01FF.
- R4: Call (op 2) runs for 6 cycles: reads at PC and PC+1, a dummy read at stack SP, a write of the high byte of PC+2 at SP, a write of the low byte of PC+2 at SP-1, then a read at PC+2. Afterwards `target` = {byte at PC+2, byte at PC+1} and `sp_out` = SP-2.
- R5: Return (op 3) runs for 6 cycles: reads at PC, PC+1 and stack SP, a low byte read at SP+1, a high byte read at SP+2, then a dummy read at the popped address {high, low}. Afterwards `target` = popped address and `sp_out` = SP+2.
- R6: Interrupt return (op 4) runs for 6 cycles: reads at PC, PC+1, then stack SP, SP+1, SP+2 and SP+3. The bytes at SP+2 and SP+3 form `target` as low and high byte. `sp_out` = SP+3.
- R7: Break (op 5) runs for 7 cycles: reads at PC and PC+1, writes at stack SP, SP-1 and SP-2 carrying the high byte of PC+2, then the low byte of PC+2, then `wr_byte`, then reads at 0xFFFE and 0xFFFF. Afterwards `target` = {byte at 0xFFFF, byte at 0xFFFE} and `sp_out` = SP-3.
- R8: `done` is high for exactly one cycle, the cycle of the final bus action, and `busy` falls after it.
- R9: A start while `busy` is high has no effect on the running sequence. A start with op 6 or 7 starts nothing and leaves `sp_out` and `target` unchanged.
- R10: After reset and whenever idle, `bus_valid`, `bus_write`, `busy` and `done` are low, and `sp_out` and `target` reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| op_sel | input | 3 | Operation code, 0..5 |
| pc_in | input | 16 | Program counter at the opcode |
| sp_in | input | 8 | Stack pointer offset |
| wr_byte | input | 8 | Byte stored by push, status stored by break |
| rd_data | input | 8 | Read data for the current bus address |
| bus_valid | output | 1 | A bus action is driven this cycle |
| bus_write | output | 1 | The action is a write |
| bus_addr | output | 16 | Address of the action |
| bus_wdata | output | 8 | Write data (zero on reads) |
| busy | output | 1 | A sequence is running |
| done | output | 1 | This is the final action of the sequence |
| sp_out | output | 8 | Stack pointer after the last completed operation |
| target | output | 16 | Value fetched by the last completed operation |

## Verification
The bound assertions check the following on every cycle. Every write lands in the stack page. `done` is a one-cycle pulse that coincides with a live bus action and ends `busy`. Nothing is driven while idle. A running sequence cannot be cut short. `sp_out` moves only at completion. The sequence length matches the operation that started it. The exact address order, the write data bytes, the wrap of stack offsets across 0xFF/0x00, the fetched targets, and the ignoring of starts during a run or with unknown codes can only be shown by the bench scenarios. In those scenarios a behavioural model predicts every bus cycle from its own memory function.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;
  localparam int STEP_W = 3;
  localparam int OFF_W  = 8;

  typedef enum logic [2:0] {
    OP_PUSH = 3'd0, OP_PULL = 3'd1, OP_CALL = 3'd2,
    OP_RET  = 3'd3, OP_RTI  = 3'd4, OP_BRK  = 3'd5
  } op_e;

  typedef enum logic [1:0] {SRC_PC, SRC_STK, SRC_VEC, SRC_PTR} src_e;
  typedef enum logic [1:0] {WD_PCH, WD_PCL, WD_BYTE}           wd_e;
  typedef enum logic [1:0] {CAP_NONE, CAP_LO, CAP_HI}          cap_e;

  typedef struct packed {
    logic             wr;
    src_e             src;
    logic [OFF_W-1:0] off;
    wd_e              wd;
    cap_e             cap;
    logic             last;
  } step_t;

  function automatic step_t mk(logic wr, src_e src, logic [OFF_W-1:0] off,
                               wd_e wd, cap_e cap, logic last);
    step_t s;
    s.wr = wr; s.src = src; s.off = off; s.wd = wd; s.cap = cap; s.last = last;
    return s;
  endfunction

  function automatic logic op_known(logic [2:0] op);
    return op <= 3'd5;
  endfunction

  // Net change of the stack pointer per operation (two's complement)
  function automatic logic [OFF_W-1:0] sp_delta(logic [2:0] op);
    case (op)
      OP_PUSH: return 8'hFF;
      OP_PULL: return 8'h01;
      OP_CALL: return 8'hFE;
      OP_RET:  return 8'h02;
      OP_RTI:  return 8'h03;
      OP_BRK:  return 8'hFD;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/stk_step_rom.sv
module stk_step_rom
  import stk_seq_pkg::*;
(
  input  logic [2:0]        op,
  input  logic [STEP_W-1:0] step,
  output step_t             cur
);
  always_comb begin
    cur = mk(1'b0, SRC_PC, 8'd0, WD_BYTE, CAP_NONE, 1'b1);
    if (step == 3'd0) begin
      cur = mk(1'b0, SRC_PC, 8'd0, WD_BYTE, CAP_NONE, 1'b0);
    end else if (step == 3'd1) begin
      cur = mk(1'b0, SRC_PC, 8'd1, WD_BYTE,
               (op == OP_CALL) ? CAP_LO : CAP_NONE, 1'b0);
    end else begin
      case (op)
        OP_PUSH: cur = mk(1'b1, SRC_STK, 8'd0, WD_BYTE, CAP_NONE, 1'b1);
        OP_PULL:
          case (step)
            3'd2:    cur = mk(1'b0, SRC_STK, 8'd0, WD_BYTE, CAP_NONE, 1'b0);
            default: cur = mk(1'b0, SRC_STK, 8'd1, WD_BYTE, CAP_LO,   1'b1);
          endcase
        OP_CALL:
          case (step)
            3'd2:    cur = mk(1'b0, SRC_STK, 8'd0,   WD_BYTE, CAP_NONE, 1'b0);
            3'd3:    cur = mk(1'b1, SRC_STK, 8'd0,   WD_PCH,  CAP_NONE, 1'b0);
            3'd4:    cur = mk(1'b1, SRC_STK, 8'hFF,  WD_PCL,  CAP_NONE, 1'b0);
            default: cur = mk(1'b0, SRC_PC,  8'd2,   WD_BYTE, CAP_HI,   1'b1);
          endcase
        OP_RET:
          case (step)
            3'd2:    cur = mk(1'b0, SRC_STK, 8'd0, WD_BYTE, CAP_NONE, 1'b0);
            3'd3:    cur = mk(1'b0, SRC_STK, 8'd1, WD_BYTE, CAP_LO,   1'b0);
            3'd4:    cur = mk(1'b0, SRC_STK, 8'd2, WD_BYTE, CAP_HI,   1'b0);
            default: cur = mk(1'b0, SRC_PTR, 8'd0, WD_BYTE, CAP_NONE, 1'b1);
          endcase
        OP_RTI:
          case (step)
            3'd2:    cur = mk(1'b0, SRC_STK, 8'd0, WD_BYTE, CAP_NONE, 1'b0);
            3'd3:    cur = mk(1'b0, SRC_STK, 8'd1, WD_BYTE, CAP_NONE, 1'b0);
            3'd4:    cur = mk(1'b0, SRC_STK, 8'd2, WD_BYTE, CAP_LO,   1'b0);
            default: cur = mk(1'b0, SRC_STK, 8'd3, WD_BYTE, CAP_HI,   1'b1);
          endcase
        default:
          case (step)
            3'd2:    cur = mk(1'b1, SRC_STK, 8'd0,  WD_PCH,  CAP_NONE, 1'b0);
            3'd3:    cur = mk(1'b1, SRC_STK, 8'hFF, WD_PCL,  CAP_NONE, 1'b0);
            3'd4:    cur = mk(1'b1, SRC_STK, 8'hFE, WD_BYTE, CAP_NONE, 1'b0);
            3'd5:    cur = mk(1'b0, SRC_VEC, 8'd0,  WD_BYTE, CAP_LO,   1'b0);
            default: cur = mk(1'b0, SRC_VEC, 8'd1,  WD_BYTE, CAP_HI,   1'b1);
          endcase
      endcase
    end
  end
endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen
  import stk_seq_pkg::*;
#(
  parameter int                  ADDR_W     = 16,
  parameter logic [ADDR_W-9:0]   STACK_PAGE = 'h01,
  parameter logic [ADDR_W-1:0]   VEC_BASE   = '1 - 1
) (
  input  src_e              src,
  input  logic [OFF_W-1:0]  off,
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  sp,
  input  logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] addr
);
  logic [OFF_W-1:0] stk_lo;
  assign stk_lo = sp + off;   // wraps inside the page

  always_comb begin
    case (src)
      SRC_PC:  addr = pc + ADDR_W'(off);
      SRC_STK: addr = {STACK_PAGE, stk_lo};
      SRC_VEC: addr = VEC_BASE + ADDR_W'(off);
      default: addr = ptr;
    endcase
  end
endmodule

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
  import stk_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_ok,
  input  logic              last,
  output logic              accept,
  output logic              busy,
  output logic [STEP_W-1:0] step
);
  assign accept = start & op_ok & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      step <= '0;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
        step <= '0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end
endmodule

// File: rtl/stk_bus_seq.sv
module stk_bus_seq
  import stk_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int DW    = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op_sel,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DW-1:0]     sp_in,
  input  logic [DW-1:0]     wr_byte,
  input  logic [DW-1:0]     rd_data,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DW-1:0]     bus_wdata,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     sp_out,
  output logic [ADDR_W-1:0] target
);
  logic              accept;
  logic [STEP_W-1:0] step;
  step_t             cur;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] pc_q, pc_ret, addr_raw;
  logic [DW-1:0]     sp_q, wb_q, lo_q, hi_q, lo_n, hi_n;

  stk_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_ok(op_known(op_sel)),
    .last(cur.last), .accept(accept), .busy(busy), .step(step)
  );

  stk_step_rom u_rom (.op(op_q), .step(step), .cur(cur));

  stk_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .src(cur.src), .off(cur.off), .pc(pc_q), .sp(sp_q),
    .ptr({hi_q, lo_q}), .addr(addr_raw)
  );

  assign pc_ret = pc_q + ADDR_W'(2);
  assign lo_n   = (cur.cap == CAP_LO) ? rd_data : lo_q;
  assign hi_n   = (cur.cap == CAP_HI) ? rd_data : hi_q;

  assign bus_valid = busy;
  assign bus_write = busy & cur.wr;
  assign bus_addr  = busy ? addr_raw : '0;
  assign done      = busy & cur.last;

  always_comb begin
    bus_wdata = '0;
    if (bus_write) begin
      case (cur.wd)
        WD_PCH:  bus_wdata = pc_ret[ADDR_W-1:DW];
        WD_PCL:  bus_wdata = pc_ret[DW-1:0];
        default: bus_wdata = wb_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= '0;
      pc_q   <= '0;
      sp_q   <= '0;
      wb_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      sp_out <= '0;
      target <= '0;
    end else if (accept) begin
      op_q <= op_sel;
      pc_q <= pc_in;
      sp_q <= sp_in;
      wb_q <= wr_byte;
      lo_q <= '0;
      hi_q <= '0;
    end else if (busy) begin
      lo_q <= lo_n;
      hi_q <= hi_n;
      if (cur.last) begin
        sp_out <= sp_q + sp_delta(op_q);
        target <= {hi_n, lo_n};
      end
    end
  end
endmodule

// File: rtl/stk_bus_seq_chk.sv
module stk_bus_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [2:0] op_sel,
  input logic       busy,
  input logic       done,
  input logic       bus_valid,
  input logic       bus_write,
  input logic [7:0] addr_hi,
  input logic [7:0] sp_out
);
  logic [2:0] op_cap;
  logic [3:0] cnt;
  logic [3:0] exp_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_cap <= '0;
      cnt    <= '0;
    end else if (start && !busy && op_sel <= 3'd5) begin
      op_cap <= op_sel;
      cnt    <= 4'd1;
    end else if (busy) begin
      cnt <= cnt + 4'd1;
    end
  end

  always_comb begin
    case (op_cap)
      3'd0:    exp_len = 4'd3;
      3'd1:    exp_len = 4'd4;
      3'd5:    exp_len = 4'd7;
      default: exp_len = 4'd6;
    endcase
  end

  p_write_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write) |-> addr_hi == 8'h01);
  p_done_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bus_valid);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_no_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_valid && !bus_write && !done));
  p_sp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(sp_out));
  p_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cnt == exp_len);
endmodule

bind stk_bus_seq stk_bus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .busy(busy),
  .done(done), .bus_valid(bus_valid), .bus_write(bus_write),
  .addr_hi(bus_addr[15:8]), .sp_out(sp_out)
);

// File: tb/sim_stk_bus_seq.sv
module sim_stk_bus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  sp_in = '0;
  logic [7:0]  wr_byte = '0;
  logic [7:0]  rd_data;
  logic        bus_valid, bus_write, busy, done;
  logic [15:0] bus_addr, target;
  logic [7:0]  bus_wdata, sp_out;

  int checks = 0;
  int fails  = 0;
  logic [15:0] q_addr[$];
  bit          q_wr[$];
  logic [7:0]  q_dat[$];
  logic [7:0]  last_sp = '0;
  logic [15:0] last_tgt = '0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
  endfunction

  assign rd_data = mem(bus_addr);

  stk_bus_seq u0 (.*);

  function automatic logic [15:0] stk(input logic [7:0] s, input logic [7:0] k);
    logic [7:0] lo;
    lo = s + k;
    return {8'h01, lo};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic add(input bit w, input logic [15:0] a, input logic [7:0] d);
    q_wr.push_back(w); q_addr.push_back(a); q_dat.push_back(d);
  endtask

  task automatic run_op(input int op, input logic [15:0] pc, input logic [7:0] sp,
                        input logic [7:0] wb, input bit poke, input string req);
    logic [15:0] r2, ptr, tgt;
    logic [7:0]  spx;
    int n;
    r2 = pc + 16'd2;
    q_addr.delete(); q_wr.delete(); q_dat.delete();
    add(0, pc, 0);
    add(0, pc + 16'd1, 0);
    tgt = 16'h0000; spx = sp;
    case (op)
      0: begin add(1, stk(sp, 0), wb); spx = sp - 8'd1; end
      1: begin add(0, stk(sp, 0), 0); add(0, stk(sp, 1), 0);
               tgt = {8'h00, mem(stk(sp, 1))}; spx = sp + 8'd1; end
      2: begin add(0, stk(sp, 0), 0); add(1, stk(sp, 0), r2[15:8]);
               add(1, stk(sp, 8'hFF), r2[7:0]); add(0, r2, 0);
               tgt = {mem(r2), mem(pc + 16'd1)}; spx = sp - 8'd2; end
      3: begin ptr = {mem(stk(sp, 2)), mem(stk(sp, 1))};
               add(0, stk(sp, 0), 0); add(0, stk(sp, 1), 0);
               add(0, stk(sp, 2), 0); add(0, ptr, 0);
               tgt = ptr; spx = sp + 8'd2; end
      4: begin add(0, stk(sp, 0), 0); add(0, stk(sp, 1), 0);
               add(0, stk(sp, 2), 0); add(0, stk(sp, 3), 0);
               tgt = {mem(stk(sp, 3)), mem(stk(sp, 2))}; spx = sp + 8'd3; end
      default: begin add(1, stk(sp, 0), r2[15:8]); add(1, stk(sp, 8'hFF), r2[7:0]);
               add(1, stk(sp, 8'hFE), wb); add(0, 16'hFFFE, 0); add(0, 16'hFFFF, 0);
               tgt = {mem(16'hFFFF), mem(16'hFFFE)}; spx = sp - 8'd3; end
    endcase
    n = q_addr.size();
    @(negedge clk);
    op_sel = 3'(op); pc_in = pc; sp_in = sp; wr_byte = wb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk(bus_valid === 1'b1 && busy === 1'b1, req, "busy/valid", {busy, bus_valid}, 2'b11);
      chk(bus_write === q_wr[i] && bus_addr === q_addr[i], req, "action",
          {bus_write, bus_addr}, {q_wr[i], q_addr[i]});
      if (q_wr[i]) chk(bus_wdata === q_dat[i], req, "wdata", bus_wdata, q_dat[i]);
      chk(done === (i == n - 1), "R8", "done", done, (i == n - 1));
      if (poke && i == 1) begin
        start = 1'b1; op_sel = 3'd5; pc_in = 16'hDEAD; sp_in = 8'h55; // R9 mid-run start
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    chk(busy === 1'b0 && bus_valid === 1'b0, "R10", "idle after", {busy, bus_valid}, 0);
    chk(sp_out === spx, req, "sp_out", sp_out, spx);
    chk(target === tgt, req, "target", target, tgt);
    last_sp = spx; last_tgt = tgt;
  endtask

  task automatic bad_op(input logic [2:0] code);
    @(negedge clk);
    op_sel = code; start = 1'b1; sp_in = 8'h33; pc_in = 16'h4444;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b0 && bus_valid === 1'b0, "R9", "unknown op started", {busy, bus_valid}, 0);
    @(negedge clk);
    chk(sp_out === last_sp && target === last_tgt, "R9", "unknown op changed outputs",
        {sp_out, target}, {last_sp, last_tgt});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 0 && bus_valid === 0 && bus_write === 0 && done === 0, "R10",
        "reset ctrl", {busy, bus_valid, bus_write, done}, 0);
    chk(sp_out === 0 && target === 0, "R10", "reset values", {sp_out, target}, 0);
    run_op(0, 16'h1234, 8'hFD, 8'h3C, 0, "R1");
    run_op(0, 16'hFFFF, 8'h00, 8'h81, 0, "R1");
    run_op(1, 16'h2000, 8'h80, 8'h00, 0, "R2");
    run_op(1, 16'h2010, 8'hFF, 8'h00, 0, "R3");
    run_op(2, 16'h80FF, 8'h00, 8'h00, 0, "R4");
    run_op(2, 16'h0300, 8'hF0, 8'h00, 1, "R4");
    run_op(3, 16'h0450, 8'hFE, 8'h00, 0, "R5");
    run_op(3, 16'h0460, 8'h20, 8'h00, 0, "R5");
    run_op(4, 16'h0500, 8'hFD, 8'h00, 0, "R6");
    run_op(4, 16'h0510, 8'h10, 8'h00, 1, "R6");
    run_op(5, 16'hC000, 8'h01, 8'h24, 0, "R7");
    run_op(5, 16'hC0FE, 8'hFF, 8'hE7, 0, "R7");
    bad_op(3'd6);
    bad_op(3'd7);
    run_op(0, 16'h7777, 8'h00, 8'h5A, 1, "R9");
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule